// File: doc/BRIEF.md
# Integer Add/Subtract Unit with Condition Flags

This block performs integer addition and subtraction on two operands of configurable width. It supports four operations: plain add, add with carry, plain subtract and subtract with carry. The arithmetic result is combinational. The four condition flags are negative, zero, carry and overflow. They are held in a register that loads only when the set-flags input is high, and the new value is visible on the flag output one cycle later.

The with-carry forms take their carry-in from the registered carry flag. A sequence of flag-setting operations can therefore chain a wide addition or subtraction across several words.

The carry flag is found by comparing the result with the operands, not by widening the adder. For a carry form, the comparison also takes the incoming carry into account. Overflow comes from XOR tests on the operand and result sign bits. For subtraction, carry set means no borrow.

Top module: `int_addsub_flags`

## Requirements
- R1: While reset is active and directly after reset, the flag output `flags_o` is all zero. The bit positions are `flags_o[3]`=N, `[2]`=Z, `[1]`=C and `[0]`=V.
- R2: `op_i` bit 1 selects subtract and bit 0 selects the with-carry form (00 add, 01 add with carry, 10 subtract, 11 subtract with carry). In the same cycle, `result_o` is a+b, a+b+C, a−b or a+NOT(b)+C, each modulo 2^WIDTH.
- R3: On a set-flags cycle, N takes the most significant bit of the result and Z is set exactly when the result is zero. Both are visible on `flags_o` one cycle later.
- R4: For plain add, C is set when the result is unsigned-less-than operand a.
- R5: For add with carry, C is set when the result is unsigned-less-than a. It is also set when the result equals a and the carry-in is 1.
- R6: For plain subtract, C is set when a is unsigned greater than or equal to b.
- R7: For subtract with carry, C is set when a is unsigned greater than b. It is also set when a equals b and the carry-in is 1.
- R8: For both add forms, V is the sign bit of (result XOR a) AND NOT(a XOR b).
- R9: For both subtract forms, V is the sign bit of (result XOR a) AND (a XOR b).
- R10: When `set_flags_i` is low, `flags_o` keeps its previous value and `result_o` is still produced.
- R11: The carry-in of the with-carry forms is the C bit currently on `flags_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_i | input | 2 | Operation select: bit 1 selects subtract, bit 0 selects the with-carry form |
| set_flags_i | input | 1 | Load the flag register at the next edge |
| opa_i | input | WIDTH | First operand |
| opb_i | input | WIDTH | Second operand |
| result_o | output | WIDTH | Combinational result |
| flags_o | output | 4 | Registered flags {N,Z,C,V} |

## Verification
The bench builds the block with WIDTH at 32. At this width the signed limits 0x7FFFFFFF and 0x80000000 and the all-ones word can be used directly as operands, so every overflow and wrap case is exercised. Chained with-carry sequences reach the two equality cases, where only the incoming carry decides C. A held-flag test shows that a carry form still reads the old carry while set-flags is low.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_ADC = 2'b01,
        OP_SUB = 2'b10,
        OP_SBC = 2'b11
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

    localparam int FLAG_BITS = 4;

endpackage

// File: rtl/addsub_operand.sv
// Chooses the second adder input and the carry-in for the selected operation.
module addsub_operand #(
    parameter int WIDTH = 32
) (
    input  logic [1:0]       op,
    input  logic             carry_q,
    input  logic [WIDTH-1:0] opb,
    output logic [WIDTH-1:0] b_eff,
    output logic             cin,
    output logic             is_sub,
    output logic             use_cin
);
    always_comb begin
        is_sub  = op[1];
        use_cin = op[0];
        b_eff   = is_sub ? ~opb : opb;
        if (use_cin) begin
            cin = carry_q;
        end else begin
            cin = is_sub;
        end
    end
endmodule

// File: rtl/addsub_flag_gen.sv
// Derives N, Z, C, V from the result and the operands using comparisons.
module addsub_flag_gen
    import addsub_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic [WIDTH-1:0] sum,
    input  logic             is_sub,
    input  logic             use_cin,
    input  logic             carry_q,
    output nzcv_t            flags
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] ovf_vec;
    logic             add_c;
    logic             sub_c;

    always_comb begin
        if (use_cin) begin
            add_c = ((sum == opa) && carry_q) || (sum < opa);
            sub_c = ((opa == opb) && carry_q) || (opa > opb);
        end else begin
            add_c = (sum < opa);
            sub_c = (opa >= opb);
        end

        if (is_sub) begin
            ovf_vec = (sum ^ opa) & (opa ^ opb);
        end else begin
            ovf_vec = (sum ^ opa) & ~(opa ^ opb);
        end

        flags.n = sum[MSB];
        flags.z = (sum == '0);
        flags.c = is_sub ? sub_c : add_c;
        flags.v = ovf_vec[MSB];
    end
endmodule

// File: rtl/int_addsub_flags.sv
module int_addsub_flags
    import addsub_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       op_i,
    input  logic             set_flags_i,
    input  logic [WIDTH-1:0] opa_i,
    input  logic [WIDTH-1:0] opb_i,
    output logic [WIDTH-1:0] result_o,
    output logic [3:0]       flags_o
);
    localparam int MSB = WIDTH - 1;

    typedef struct packed {
        nzcv_t flags;
    } state_t;

    state_t st_d, st_q;

    logic [WIDTH-1:0] b_eff;
    logic             cin;
    logic             is_sub;
    logic             use_cin;
    logic [WIDTH-1:0] sum;
    nzcv_t            new_flags;

    addsub_operand #(.WIDTH(WIDTH)) u_operand (
        .op      (op_i),
        .carry_q (st_q.flags.c),
        .opb     (opb_i),
        .b_eff   (b_eff),
        .cin     (cin),
        .is_sub  (is_sub),
        .use_cin (use_cin)
    );

    assign sum = opa_i + b_eff + {{(WIDTH-1){1'b0}}, cin};

    addsub_flag_gen #(.WIDTH(WIDTH)) u_flags (
        .opa     (opa_i),
        .opb     (opb_i),
        .sum     (sum),
        .is_sub  (is_sub),
        .use_cin (use_cin),
        .carry_q (st_q.flags.c),
        .flags   (new_flags)
    );

    always_comb begin
        st_d = st_q;
        if (set_flags_i) begin
            st_d.flags = new_flags;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result_o = sum;
    assign flags_o  = st_q.flags;

    // Independent wide-adder references used only by the assertions below.
    logic [WIDTH:0] chk_add_wide;
    logic [WIDTH:0] chk_sadd;
    logic [WIDTH:0] chk_ssub;
    assign chk_add_wide = {1'b0, opa_i} + {1'b0, opb_i};
    assign chk_sadd     = {opa_i[MSB], opa_i} + {opb_i[MSB], opb_i};
    assign chk_ssub     = {opa_i[MSB], opa_i} - {opb_i[MSB], opb_i};

    a_r10_hold_flags: assert property (@(posedge clk) disable iff (!rst_n)
        !set_flags_i |=> $stable(flags_o));

    a_r3_sign_flag: assert property (@(posedge clk) disable iff (!rst_n)
        set_flags_i |=> flags_o[3] == $past(result_o[MSB]));

    a_r3_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
        set_flags_i |=> flags_o[2] == ($past(result_o) == '0));

    a_r4_add_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (set_flags_i && op_i == OP_ADD) |=> flags_o[1] == $past(chk_add_wide[WIDTH]));

    a_r8_add_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (set_flags_i && op_i == OP_ADD) |=> flags_o[0] == $past(chk_sadd[WIDTH] != chk_sadd[MSB]));

    a_r9_sub_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (set_flags_i && op_i == OP_SUB) |=> flags_o[0] == $past(chk_ssub[WIDTH] != chk_ssub[MSB]));

endmodule

// File: tb/int_addsub_flags_bench.sv
module int_addsub_flags_bench;
    localparam int W = 32;
    localparam time CLK_PERIOD = 10ns;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [1:0]   op_i;
    logic         set_flags_i;
    logic [W-1:0] opa_i, opb_i;
    logic [W-1:0] result_o;
    logic [3:0]   flags_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;
    logic [3:0] exp_f;

    always #(CLK_PERIOD/2) clk = ~clk;

    int_addsub_flags #(.WIDTH(W)) u_int_addsub_flags (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .set_flags_i(set_flags_i),
        .opa_i(opa_i), .opb_i(opb_i), .result_o(result_o), .flags_o(flags_o)
    );

    // Reference: wider adder for C, sign comparisons for V.
    function automatic logic [W+3:0] model(input logic [1:0] op, input logic [W-1:0] a,
                                           input logic [W-1:0] b, input logic cflag);
        logic [W:0]   wide;
        logic [W-1:0] bb, res;
        logic         ci, sub, n, z, c, v;
        sub  = op[1];
        bb   = sub ? ~b : b;
        ci   = op[0] ? cflag : sub;
        wide = {1'b0, a} + {1'b0, bb} + {{W{1'b0}}, ci};
        res  = wide[W-1:0];
        n    = res[W-1];
        z    = (res == '0);
        c    = wide[W];
        if (sub) v = (a[W-1] != b[W-1]) && (res[W-1] != a[W-1]);
        else     v = (a[W-1] == b[W-1]) && (res[W-1] != a[W-1]);
        return {res, n, z, c, v};
    endfunction

    task automatic check(input string tag, input string what, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic run_op(input string tag, input logic [1:0] op, input logic [W-1:0] a,
                          input logic [W-1:0] b, input logic sf);
        logic [W+3:0] e;
        @(negedge clk);
        op_i = op; opa_i = a; opb_i = b; set_flags_i = sf;
        e = model(op, a, b, exp_f[1]);
        #1;
        check(tag, "result", result_o, e[W+3:4]);
        @(negedge clk);
        if (sf) exp_f = e[3:0];
        check(tag, "flags", {{(W-4){1'b0}}, flags_o}, {{(W-4){1'b0}}, exp_f});
        set_flags_i = 1'b0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0; op_i = 2'b00; set_flags_i = 1'b0; opa_i = '0; opb_i = '0;
        exp_f = 4'b0000;
        repeat (2) @(negedge clk);
        check("R1", "flags in reset", {{(W-4){1'b0}}, flags_o}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "flags after reset", {{(W-4){1'b0}}, flags_o}, '0);
    endtask

    task automatic t_add;
        run_op("R3", 2'b00, 32'h0, 32'h0, 1'b1);
        run_op("R4", 2'b00, 32'hFFFF_FFFF, 32'h1, 1'b1);
        run_op("R8", 2'b00, 32'h7FFF_FFFF, 32'h1, 1'b1);
        run_op("R8", 2'b00, 32'h8000_0000, 32'h8000_0000, 1'b1);
        run_op("R2", 2'b00, 32'h1234_5678, 32'h1111_1111, 1'b1);
    endtask

    task automatic t_adc;
        run_op("R5", 2'b00, 32'hFFFF_FFFF, 32'h1, 1'b1);
        run_op("R5", 2'b01, 32'hFFFF_FFFF, 32'h0, 1'b1);
        run_op("R5", 2'b01, 32'h5, 32'hFFFF_FFFF, 1'b1);
        run_op("R11", 2'b01, 32'h3, 32'h4, 1'b1);
        run_op("R11", 2'b01, 32'h3, 32'h4, 1'b1);
        run_op("R8", 2'b01, 32'h7FFF_FFFF, 32'h0, 1'b1);
    endtask

    task automatic t_sub;
        run_op("R6", 2'b10, 32'h5, 32'h5, 1'b1);
        run_op("R6", 2'b10, 32'h3, 32'h5, 1'b1);
        run_op("R9", 2'b10, 32'h8000_0000, 32'h1, 1'b1);
        run_op("R9", 2'b10, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b1);
    endtask

    task automatic t_sbc;
        run_op("R7", 2'b10, 32'h3, 32'h5, 1'b1);
        run_op("R7", 2'b11, 32'h5, 32'h5, 1'b1);
        run_op("R7", 2'b11, 32'h7, 32'h5, 1'b1);
        run_op("R7", 2'b11, 32'h5, 32'h5, 1'b1);
        run_op("R11", 2'b11, 32'h0, 32'h0, 1'b1);
    endtask

    task automatic t_hold;
        run_op("R10", 2'b00, 32'hFFFF_FFFF, 32'h1, 1'b1);
        run_op("R10", 2'b10, 32'h1, 32'h2, 1'b0);
        run_op("R10", 2'b00, 32'h0, 32'h0, 1'b0);
        run_op("R11", 2'b01, 32'h10, 32'h20, 1'b0);
        run_op("R11", 2'b11, 32'h10, 32'h20, 1'b0);
    endtask

    task automatic t_random;
        for (int i = 0; i < 60; i++) begin
            logic [1:0]   op;
            logic [W-1:0] a, b;
            op = 2'($urandom_range(0, 3));
            a  = $urandom();
            b  = (i % 5 == 0) ? a : $urandom();
            run_op("R2", op, a, b, 1'($urandom_range(0, 1)));
        end
    endtask

    initial begin
        void'($urandom(17));
        t_reset();
        t_add();
        t_adc();
        t_sub();
        t_sbc();
        t_hold();
        t_random();
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule